// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block is the command-issuing core of an SDRAM controller. One state machine serves every bank of the device and puts at most one command on the command bus per clock. After reset it waits out the power-up delay and then runs a fixed start-up sequence:

- a precharge of all banks;
- two refreshes;
- a load of the standard mode register;
- optionally, a load of the extended mode register.

It then accepts accesses from the head of a request queue. For each access it picks the command sequence from the bank status reported by an external bank tracker: a row hit, a closed bank, or a different row open.

Programmable gap counters hold NOP on the bus until each command's latency has passed. The block reports back to the bank tracker when a row is opened or closed, and marks the clock in which read data is due. After a long idle stretch it lowers the clock enable to enter power-down, and it wakes when a new request shows up.

Top module: `sdram_cmd_seq`

## Requirements
- R1: During reset and through the power-up wait, `cmd` is NOP (code 0), `cke` is high, `init_done` is low and `req_ready` is low.
- R2: The first command is PRECHARGE (code 4) with address bit 10 high, issued on the T_PWRUP-th clock edge after reset release. It is followed by AUTO REFRESH (code 5) T_RP edges later, a second AUTO REFRESH T_RFC edges after that, and LOAD MODE (code 6) T_RFC edges after the second refresh.
- R3: The first LOAD MODE uses bank 0 and the address value CAS_LAT*16 + BURST_ILV*8 + log2(BURST_LEN).
- R4: With EXT_MR_EN set, a second LOAD MODE to bank 2 carrying EMR_VAL follows T_MRD edges after the first. With it clear, only one LOAD MODE is issued and the block goes idle after it.
- R5: `req_ready` first rises T_MRD-1 edges after the last LOAD MODE. `init_done` is high from the last LOAD MODE onward. A request is taken on an edge where `req_valid` and `req_ready` are both high.
- R6: With `bank_open` and `row_match` both high, READ (code 2) or WRITE (code 3) is issued on the accepting edge. Its address is the column, with bit 10 equal to `req_autopre`.
- R7: With `bank_open` low, ACTIVE (code 1) with the row and bank is issued on the accepting edge, and the READ/WRITE follows T_RCD edges later.
- R8: With `bank_open` high and `row_match` low, PRECHARGE to that bank with address bit 10 low is issued on the accepting edge. ACTIVE follows T_RP edges later, and READ/WRITE T_RCD edges after that.
- R9: After a READ/WRITE, `req_ready` rises G-1 edges later, so the next command can follow no sooner than G edges after it. G is set as follows:
  - read or write without auto-precharge: BURST_LEN/2;
  - read with auto-precharge: BURST_LEN/2 + T_RP;
  - write with auto-precharge: BURST_LEN/2 + T_WR + T_RP.
- R10: `ev_open` is high with every ACTIVE. `ev_close` is high with a single-bank PRECHARGE and with an auto-precharge READ/WRITE. Neither is high with any other command.
- R11: `rd_due` pulses CAS_LAT edges after a READ is issued.
- R12: After IDLE_PD consecutive edges in idle with `req_valid` low, `cke` goes low. While it is low, `cmd` is NOP and `req_ready` is low.
- R13: When `req_valid` rises during power-down, `cke` returns high on the next edge and the request is accepted T_XP edges after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Queue head holds an access |
| req_write | input | 1 | Access is a write |
| req_autopre | input | 1 | Close the row after this access |
| req_bank | input | BANK_W | Access bank |
| req_row | input | ROW_W | Access row |
| req_col | input | COL_W | Access start column |
| bank_open | input | 1 | Tracker: the access bank has a row open |
| row_match | input | 1 | Tracker: the open row equals req_row |
| req_ready | output | 1 | Access is taken this edge if valid |
| cmd | output | 3 | Command code |
| cmd_bank | output | BANK_W | Command bank |
| cmd_addr | output | ADDR_W | Command address |
| cke | output | 1 | Clock enable, low in power-down |
| init_done | output | 1 | Start-up sequence finished |
| ev_open | output | 1 | A row is opened this cycle |
| ev_close | output | 1 | A row is closed this cycle |
| rd_due | output | 1 | Read data is due this cycle |

## Verification
Every result is registered, so each command appears on the edge that decides it. The bench timestamps each non-NOP command, each rising edge of `req_ready`, each `rd_due` pulse and each change of `cke` against an edge counter, and samples on falling edges. The expected edge numbers are built from the timing parameters:
- the accepting edge, plus T_RP and T_RCD for each step of a row miss or a closed bank;
- the READ/WRITE edge plus G-1 for the return of `req_ready`;
- the READ edge plus CAS_LAT for `rd_due`;
- the accepting edge plus IDLE_PD for power-down entry;
- the wake edge plus T_XP for the next accepted access.

Between accesses the bench waits long enough that every event of the previous access has been logged before it compares.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int CNT_W     = 16,
  parameter int T_PWRUP   = 20,
  parameter int T_RP      = 2,
  parameter int T_RCD     = 3,
  parameter int T_RFC     = 5,
  parameter int T_MRD     = 2,
  parameter int T_WR      = 2,
  parameter int T_XP      = 2,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter int BURST_ILV = 0,
  parameter int DDR       = 1,
  parameter int EXT_MR_EN = 1,
  parameter int EMR_VAL   = 0,
  parameter int IDLE_PD   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_autopre,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              bank_open,
  input  logic              row_match,
  output logic              req_ready,
  output logic [2:0]        cmd,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cke,
  output logic              init_done,
  output logic              ev_open,
  output logic              ev_close,
  output logic              rd_due
);

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_LMR = 3'd6;
  localparam int BURST_CYC = (DDR != 0) ? BURST_LEN / 2 : BURST_LEN;
  localparam logic [ADDR_W-1:0] MR_VAL =
    ADDR_W'((CAS_LAT << 4) | (BURST_ILV << 3) | $clog2(BURST_LEN));
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AP_BIT;

  typedef enum logic [3:0] {
    S_PREA, S_REF1, S_REF2, S_MRS, S_EMRS, S_IDLE, S_ACT, S_RW, S_PD
  } st_t;

  st_t               st, n_st;
  logic [CNT_W-1:0]  cnt, idle_cnt, n_gap;
  logic              go, accept, n_cke, n_eo, n_ec;
  logic [2:0]        n_cmd;
  logic [BANK_W-1:0] n_bank, q_bank;
  logic [ADDR_W-1:0] n_addr;
  logic [ROW_W-1:0]  q_row;
  logic [COL_W-1:0]  q_col;
  logic              q_wr, q_ap;
  logic [CAS_LAT:0]  rd_pipe;

  function automatic logic [ADDR_W-1:0] col_addr(input logic [COL_W-1:0] c, input logic ap);
    logic [ADDR_W-1:0] a;
    a = '0;
    a[COL_W-1:0] = c;
    a[AP_BIT] = ap;
    return a;
  endfunction

  function automatic logic [ADDR_W-1:0] row_addr(input logic [ROW_W-1:0] r);
    logic [ADDR_W-1:0] a;
    a = '0;
    a[ROW_W-1:0] = r;
    return a;
  endfunction

  function automatic logic [CNT_W-1:0] rw_gap(input logic wr, input logic ap);
    if (!ap)     return CNT_W'(BURST_CYC);
    else if (wr) return CNT_W'(BURST_CYC + T_WR + T_RP);
    else         return CNT_W'(BURST_CYC + T_RP);
  endfunction

  assign go        = (cnt == '0);
  assign req_ready = (st == S_IDLE) && go;
  assign accept    = req_valid && req_ready;
  assign rd_due    = rd_pipe[CAS_LAT];

  always_comb begin
    n_st   = st;
    n_cmd  = C_NOP;
    n_bank = cmd_bank;
    n_addr = cmd_addr;
    n_gap  = '0;
    n_cke  = cke;
    n_eo   = 1'b0;
    n_ec   = 1'b0;
    case (st)
      S_PREA: if (go) begin
        n_cmd = C_PRE; n_bank = '0; n_addr = ALL_BANKS;
        n_gap = CNT_W'(T_RP); n_st = S_REF1;
      end
      S_REF1: if (go) begin
        n_cmd = C_REF; n_gap = CNT_W'(T_RFC); n_st = S_REF2;
      end
      S_REF2: if (go) begin
        n_cmd = C_REF; n_gap = CNT_W'(T_RFC); n_st = S_MRS;
      end
      S_MRS: if (go) begin
        n_cmd = C_LMR; n_bank = '0; n_addr = MR_VAL; n_gap = CNT_W'(T_MRD);
        n_st = (EXT_MR_EN != 0) ? S_EMRS : S_IDLE;
      end
      S_EMRS: if (go) begin
        n_cmd = C_LMR; n_bank = BANK_W'(2); n_addr = ADDR_W'(EMR_VAL);
        n_gap = CNT_W'(T_MRD); n_st = S_IDLE;
      end
      S_IDLE: begin
        if (accept) begin
          n_bank = req_bank;
          if (!bank_open) begin
            n_cmd = C_ACT; n_addr = row_addr(req_row); n_eo = 1'b1;
            n_gap = CNT_W'(T_RCD); n_st = S_RW;
          end else if (row_match) begin
            n_cmd = req_write ? C_WR : C_RD;
            n_addr = col_addr(req_col, req_autopre);
            n_ec = req_autopre;
            n_gap = rw_gap(req_write, req_autopre);
          end else begin
            n_cmd = C_PRE; n_addr = '0; n_ec = 1'b1;
            n_gap = CNT_W'(T_RP); n_st = S_ACT;
          end
        end else if (go && !req_valid && idle_cnt >= CNT_W'(IDLE_PD - 1)) begin
          n_cke = 1'b0; n_st = S_PD;
        end
      end
      S_ACT: if (go) begin
        n_cmd = C_ACT; n_bank = q_bank; n_addr = row_addr(q_row); n_eo = 1'b1;
        n_gap = CNT_W'(T_RCD); n_st = S_RW;
      end
      S_RW: if (go) begin
        n_cmd = q_wr ? C_WR : C_RD; n_bank = q_bank;
        n_addr = col_addr(q_col, q_ap); n_ec = q_ap;
        n_gap = rw_gap(q_wr, q_ap); n_st = S_IDLE;
      end
      S_PD: if (req_valid) begin
        n_cke = 1'b1; n_gap = CNT_W'(T_XP); n_st = S_IDLE;
      end
      default: n_st = S_PREA;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PREA;
      cnt       <= CNT_W'(T_PWRUP - 1);
      idle_cnt  <= '0;
      cmd       <= C_NOP;
      cmd_bank  <= '0;
      cmd_addr  <= '0;
      cke       <= 1'b1;
      init_done <= 1'b0;
      ev_open   <= 1'b0;
      ev_close  <= 1'b0;
      rd_pipe   <= '0;
      q_bank    <= '0;
      q_row     <= '0;
      q_col     <= '0;
      q_wr      <= 1'b0;
      q_ap      <= 1'b0;
    end else begin
      st        <= n_st;
      cmd       <= n_cmd;
      cmd_bank  <= n_bank;
      cmd_addr  <= n_addr;
      cke       <= n_cke;
      ev_open   <= n_eo;
      ev_close  <= n_ec;
      init_done <= init_done || (n_st == S_IDLE);
      rd_pipe   <= {rd_pipe[CAS_LAT-1:0], n_cmd == C_RD};
      if (n_gap != '0)  cnt <= n_gap - CNT_W'(1);
      else if (!go)     cnt <= cnt - CNT_W'(1);
      if (st == S_IDLE && !req_valid) begin
        if (idle_cnt != '1) idle_cnt <= idle_cnt + CNT_W'(1);
      end else begin
        idle_cnt <= '0;
      end
      if (accept) begin
        q_bank <= req_bank;
        q_row  <= req_row;
        q_col  <= req_col;
        q_wr   <= req_write;
        q_ap   <= req_autopre;
      end
    end
  end

  logic [2:0]       chk_last;
  logic [CNT_W-1:0] chk_since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_last  <= C_NOP;
      chk_since <= '0;
    end else if (cmd != C_NOP) begin
      chk_last  <= cmd;
      chk_since <= CNT_W'(1);
    end else if (chk_since != '1) begin
      chk_since <= chk_since + CNT_W'(1);
    end
  end

  // R12
  pd_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cmd == C_NOP && !req_ready));

  // R5
  access_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT || cmd == C_RD || cmd == C_WR) |-> init_done);

  // R8
  rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT && chk_last == C_PRE) |-> chk_since >= CNT_W'(T_RP));

  // R7
  rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == C_RD || cmd == C_WR) && chk_last == C_ACT) |-> chk_since >= CNT_W'(T_RCD));

  // R10
  open_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_open |-> !ev_close);

endmodule

// File: tb/test_sdram_cmd_seq.sv
module test_sdram_cmd_seq;
  localparam int T_PWRUP = 20, T_RP = 2, T_RCD = 3, T_RFC = 5, T_MRD = 2;
  localparam int T_WR = 2, T_XP = 2, CAS = 3, BCYC = 2, IDLE_PD = 40;
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_LMR = 3'd6;
  // fields: write, autopre, bank_open, row_match, bank[2], row[13], col[10]
  localparam logic [28:0] VECS [6] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 13'h0123, 10'h005},
    {1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 13'h0123, 10'h008},
    {1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 13'h01AB, 10'h3F0},
    {1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 13'h1F00, 10'h011},
    {1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 13'h0042, 10'h2AA},
    {1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 13'h0777, 10'h155}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_autopre = 0, bank_open = 0, row_match = 0;
  logic [1:0] req_bank = 0;
  logic [12:0] req_row = 0;
  logic [9:0] req_col = 0;
  logic req_ready, cke, init_done, ev_open, ev_close, rd_due;
  logic [2:0] cmd;
  logic [1:0] cmd_bank;
  logic [12:0] cmd_addr;
  logic ready2, cke2, done2, eo2, ec2, rd2;
  logic [2:0] cmd2;
  logic [1:0] bank2;
  logic [12:0] addr2;

  always #5 clk = ~clk;

  sdram_cmd_seq i_sdram_cmd_seq (
    .clk, .rst_n, .req_valid, .req_write, .req_autopre, .req_bank, .req_row, .req_col,
    .bank_open, .row_match, .req_ready, .cmd, .cmd_bank, .cmd_addr, .cke, .init_done,
    .ev_open, .ev_close, .rd_due);

  sdram_cmd_seq #(.EXT_MR_EN(0)) i_noext (
    .clk, .rst_n, .req_valid(1'b0), .req_write(1'b0), .req_autopre(1'b0),
    .req_bank(2'd0), .req_row(13'd0), .req_col(10'd0), .bank_open(1'b0),
    .row_match(1'b0), .req_ready(ready2), .cmd(cmd2), .cmd_bank(bank2),
    .cmd_addr(addr2), .cke(cke2), .init_done(done2), .ev_open(eo2),
    .ev_close(ec2), .rd_due(rd2));

  int n_chk = 0, n_err = 0, cyc = 0, n_log = 0, last_c0 = 0;
  int rdy_rise = -1, rd_cyc = -1, pd_cyc = -1, wake_cyc = -1, n_lmr2 = 0, r2_rise = -1;
  logic rdy_q = 0, cke_q = 1, r2_q = 0;
  logic [2:0] lcmd [64];
  logic [1:0] lbank [64];
  logic [12:0] laddr [64];
  logic leo [64], lec [64];
  int lcyc [64];

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (cmd != C_NOP && n_log < 64) begin
      lcmd[n_log] = cmd; lbank[n_log] = cmd_bank; laddr[n_log] = cmd_addr;
      leo[n_log] = ev_open; lec[n_log] = ev_close; lcyc[n_log] = cyc;
      n_log++;
    end
    if (req_ready && !rdy_q) rdy_rise = cyc;
    rdy_q = req_ready;
    if (rd_due) rd_cyc = cyc;
    if (!cke && cke_q) pd_cyc = cyc;
    if (cke && !cke_q) wake_cyc = cyc;
    cke_q = cke;
    if (cmd2 == C_LMR) n_lmr2++;
    if (ready2 && !r2_q && r2_rise < 0) r2_rise = cyc;
    r2_q = ready2;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [28:0] v);
    int c0, start, idx, t, gap;
    logic wr, ap, op, hit;
    {wr, ap, op, hit} = v[28:25];
    @(negedge clk);
    req_write = wr; req_autopre = ap; bank_open = op; row_match = hit;
    req_bank = v[24:23]; req_row = v[22:10]; req_col = v[9:0]; req_valid = 1;
    while (!req_ready) @(negedge clk);
    c0 = cyc + 1; start = n_log; last_c0 = c0;
    @(negedge clk);
    req_valid = 0;
    repeat (20) @(posedge clk);
    idx = start; t = c0;
    if (op && !hit) begin
      chk("R8 pre cmd", lcmd[idx], C_PRE);
      chk("R8 pre bank", lbank[idx], v[24:23]);
      chk("R8 pre a10", laddr[idx][10], 0);
      chk("R8 pre cycle", lcyc[idx], t);
      chk("R10 pre close", lec[idx], 1);
      idx++; t += T_RP;
    end
    if (!(op && hit)) begin
      chk("R7 act cmd", lcmd[idx], C_ACT);
      chk("R7 act row", laddr[idx], v[22:10]);
      chk("R7 act bank", lbank[idx], v[24:23]);
      chk("R7 act cycle", lcyc[idx], t);
      chk("R10 act open", leo[idx], 1);
      idx++; t += T_RCD;
    end
    chk("R6 rw cmd", lcmd[idx], wr ? C_WR : C_RD);
    chk("R6 rw addr", laddr[idx], (int'(ap) << 10) | int'(v[9:0]));
    chk("R6 rw bank", lbank[idx], v[24:23]);
    chk("R6 rw cycle", lcyc[idx], t);
    chk("R10 rw close", lec[idx], ap);
    chk("R10 rw open", leo[idx], 0);
    chk("R6 command count", n_log, idx + 1);
    gap = !ap ? BCYC : (wr ? BCYC + T_WR + T_RP : BCYC + T_RP);
    chk("R9 ready return", rdy_rise, t + gap - 1);
    if (!wr) chk("R11 read data due", rd_cyc, t + CAS);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cmd", cmd, C_NOP);
    chk("R1 reset cke", cke, 1);
    chk("R1 reset init_done", init_done, 0);
    chk("R1 reset ready", req_ready, 0);
    rst_n = 1;
    repeat (T_PWRUP - 2) @(negedge clk);
    chk("R1 wait cmd", cmd, C_NOP);
    chk("R1 wait ready", req_ready, 0);
    repeat (T_RP + 2 * T_RFC + 2 * T_MRD + 8) @(posedge clk);
    chk("R2 pre cmd", lcmd[0], C_PRE);
    chk("R2 pre all a10", laddr[0][10], 1);
    chk("R2 pre cycle", lcyc[0], T_PWRUP);
    chk("R10 pre-all no close", lec[0], 0);
    chk("R2 ref1", lcmd[1], C_REF);
    chk("R2 ref1 cycle", lcyc[1], T_PWRUP + T_RP);
    chk("R2 ref2", lcmd[2], C_REF);
    chk("R2 ref2 cycle", lcyc[2], T_PWRUP + T_RP + T_RFC);
    chk("R2 lmr cmd", lcmd[3], C_LMR);
    chk("R2 lmr cycle", lcyc[3], T_PWRUP + T_RP + 2 * T_RFC);
    chk("R3 lmr bank", lbank[3], 0);
    chk("R3 lmr value", laddr[3], CAS * 16 + 2);
    chk("R4 emr cmd", lcmd[4], C_LMR);
    chk("R4 emr bank", lbank[4], 2);
    chk("R4 emr value", laddr[4], 0);
    chk("R4 emr cycle", lcyc[4], T_PWRUP + T_RP + 2 * T_RFC + T_MRD);
    chk("R5 ready rise", rdy_rise, T_PWRUP + T_RP + 2 * T_RFC + 2 * T_MRD - 1);
    chk("R5 init_done", init_done, 1);
    chk("R4 no-ext lmr count", n_lmr2, 1);
    chk("R4 no-ext ready rise", r2_rise, T_PWRUP + T_RP + 2 * T_RFC + T_MRD - 1);
    chk("R4 no-ext init_done", done2, 1);
    chk("R5 init command count", n_log, 5);

    for (int i = 0; i < 6; i++) run_vec(VECS[i]);

    run_vec({1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 13'h0005, 10'h00C});
    repeat (IDLE_PD) @(posedge clk);
    chk("R12 power-down entry", pd_cyc, last_c0 + IDLE_PD);
    @(negedge clk);
    chk("R12 pd cke", cke, 0);
    chk("R12 pd cmd", cmd, C_NOP);
    chk("R12 pd ready", req_ready, 0);
    run_vec({1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 13'h0005, 10'h010});
    chk("R13 wake accept", last_c0, wake_cyc + T_XP);
    chk("R13 wake cke", cke, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule